// File: doc/BRIEF.md
# Dual-Edge GPIO Interrupt Controller

This block turns level changes on a port of already-synchronized GPIO pins into latched interrupt events and merges them into one request line for a parent interrupt controller. For each pin, software chooses whether a rising edge, a falling edge, both, or neither records an event. Two independent per-pin enable masks make that choice. There is no level-triggered mode. The block detects an edge by comparing the current pin sample with the sample taken one clock earlier.

A recorded event sets the pin's bit in a read-only pending register. That bit stays set until software writes a one to the same bit position at the acknowledge address. The combined request output is registered and stays high while any pending bit is set. The service routine reads the pending register, handles the lowest set bit, acknowledges it, and repeats until the register reads zero. Out of reset, every pin records falling edges only.

The register port is a simple single-cycle write strobe with a 2-bit selector, and a 2-bit read selector with registered read data.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the rising-enable mask reads 0, the falling-enable mask reads all ones, the pending register reads 0 and `irq_o` is 0.
- R2: Selector encoding: 0 is the rising-enable mask (read/write), 1 is the falling-enable mask (read/write), 2 is the pending register (read-only), and 3 is the acknowledge address (write-only, reads as 0). `rd_data` shows the register chosen by `rd_sel` one clock after it is presented.
- R3: A 0-to-1 change on a pin whose rising-enable bit is 1 sets that pin's pending bit at the first clock edge that samples the new level.
- R4: A 1-to-0 change on a pin whose falling-enable bit is 1 sets that pin's pending bit at the first clock edge that samples the new level.
- R5: With both enable bits set, either edge is recorded. With both clear, no edge is recorded. Setting an enable bit afterwards does not record an edge that has already passed.
- R6: Writing to selector 3 clears every pending bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. Pending bits are cleared only this way; changing a mask does not clear them.
- R7: If an enabled edge on a pin falls in the same clock as an acknowledge of that pin, the pending bit stays set.
- R8: `irq_o` is a register that is 1 exactly when the pending register is nonzero, and it updates on the same clock edge as the pending register.
- R9: A write to selector 2 leaves the pending register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | WIDTH | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | WIDTH | Write data |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | WIDTH | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can land on the same clock: a new enabled edge on a pin, and an acknowledge write that clears that same pin. The bench provokes this by toggling a pin back to its idle level, then driving the next falling edge and the acknowledge write on the same falling clock edge. The new event must win. It judges the result by reading the pending register afterwards and expecting the bit still set. A second acknowledge with no coincident edge must then clear the bit and drop `irq_o` on that same edge.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  typedef enum logic [1:0] {
    SEL_RISE = 2'd0,
    SEL_FALL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_ACK  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/edge_sense.sv
module edge_sense #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] pin_lvl,
  output logic [WIDTH-1:0] rise_ev,
  output logic [WIDTH-1:0] fall_ev
);
  logic [WIDTH-1:0] last_lvl;

  // Previous sample follows the pin even in reset, so release brings no false edge.
  always_ff @(posedge clk) last_lvl <= pin_lvl;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign rise_ev[i] =  pin_lvl[i] & ~last_lvl[i];
    assign fall_ev[i] = ~pin_lvl[i] &  last_lvl[i];
  end
endmodule

// File: rtl/pend_bank.sv
module pend_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] hit,
  input  logic [WIDTH-1:0] ack,
  output logic [WIDTH-1:0] pend,
  output logic             any_nxt
);
  logic [WIDTH-1:0] pend_nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // A fresh event outranks an acknowledge of the same bit.
    assign pend_nxt[i] = hit[i] | (pend[i] & ~ack[i]);
    always_ff @(posedge clk) begin
      if (rst) pend[i] <= 1'b0;
      else     pend[i] <= pend_nxt[i];
    end
  end

  assign any_nxt = |pend_nxt;

  AST_SET_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend) & ~$past(hit)) == '0)); // R5
  AST_CLR_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    (($past(pend) & ~pend & ~$past(ack)) == '0)); // R6
  AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
    (($past(hit) & ~pend) == '0)); // R7
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import edge_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  input  logic [WIDTH-1:0] status,
  output logic [WIDTH-1:0] rise_en,
  output logic [WIDTH-1:0] fall_en,
  output logic [WIDTH-1:0] ack,
  output logic [WIDTH-1:0] rd_data
);
  reg_sel_e wsel, rsel;
  assign wsel = reg_sel_e'(wr_sel);
  assign rsel = reg_sel_e'(rd_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en <= '0;
      fall_en <= '1;
    end else if (wr_en) begin
      if (wsel == SEL_RISE) rise_en <= wr_data;
      if (wsel == SEL_FALL) fall_en <= wr_data;
    end
  end

  assign ack = (wr_en && wsel == SEL_ACK) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (rsel)
        SEL_RISE: rd_data <= rise_en;
        SEL_FALL: rd_data <= fall_en;
        SEL_STAT: rd_data <= status;
        default:  rd_data <= '0;
      endcase
    end
  end

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsel == SEL_ACK) |=> (rd_data == '0)); // R2
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> ($stable(rise_en) && $stable(fall_en))); // R2
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_lvl,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [WIDTH-1:0] rd_data,
  output logic             irq_o
);
  logic [WIDTH-1:0] rise_ev, fall_ev, rise_en, fall_en, ack, hit, status;
  logic             any_nxt;

  edge_sense #(.WIDTH(WIDTH)) u_sense (
    .clk(clk), .pin_lvl(pin_lvl), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  irq_cfg_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .status(status), .rise_en(rise_en), .fall_en(fall_en),
    .ack(ack), .rd_data(rd_data)
  );

  assign hit = (rise_ev & rise_en) | (fall_ev & fall_en);

  pend_bank #(.WIDTH(WIDTH)) u_pend (
    .clk(clk), .rst(rst), .hit(hit), .ack(ack), .pend(status), .any_nxt(any_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= any_nxt;
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_o == (status != '0)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_o && status == '0)); // R1
endmodule

// File: tb/sim_edge_irq_ctrl.sv
module sim_edge_irq_ctrl;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_RISE = 2'd0, S_FALL = 2'd1, S_STAT = 2'd2, S_ACK = 2'd3;

  typedef struct packed {
    logic [W-1:0] rise, fall, a, b, exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_00FF, 32'h0000_0F0F, 32'h0000_00F0},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_00FF, 32'h0000_0F0F, 32'h0000_0F00},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0000_FFFF, 32'hFFFF_FFFF},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    '{32'h0000_FFFF, 32'hFFFF_0000, 32'h1234_5678, 32'h8765_4321, 32'h1010_0101},
    '{32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0000, 32'hFFFF_FFFF, 32'hAAAA_AAAA}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pin_lvl = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_sel = '0;
  logic [W-1:0] rd_data;
  logic         irq_o;
  int           n_chk = 0;
  int           n_bad = 0;
  logic         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [W-1:0] v);
    rd_sel = s;
    step();
    v = rd_data;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] v;
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, '0);
    rd(S_RISE, v); check("R1 rise mask", v, '0);
    rd(S_FALL, v); check("R1 fall mask", v, '1);
    rd(S_STAT, v); check("R1 status", v, '0);
    rd(S_ACK, v);  check("R2 ack reads zero", v, '0);

    // Vector walk: R3 R4 R5 R8
    for (int k = 0; k < 6; k++) begin
      pin_lvl = VECS[k].a;
      step(); step();
      wr(S_RISE, VECS[k].rise);
      wr(S_FALL, VECS[k].fall);
      wr(S_ACK, '1);
      pin_lvl = VECS[k].b;
      step();
      check($sformatf("R8 irq vec%0d", k), {31'd0, irq_o}, {31'd0, VECS[k].exp != '0});
      rd(S_STAT, v);
      check($sformatf("R3/R4/R5 status vec%0d", k), v, VECS[k].exp);
    end
    rd(S_RISE, v); check("R2 rise mask readback", v, VECS[5].rise);

    // Directed tests
    pin_lvl = '0;
    do_reset();
    pin_lvl = '1; step();
    rd(S_STAT, v); check("R5 rising ignored by default masks", v, '0);
    pin_lvl = ~32'h0000_0088; step();
    check("R8 irq after falling edge", {31'd0, irq_o}, 32'd1);
    rd(S_STAT, v); check("R4 falling edges recorded", v, 32'h0000_0088);
    wr(S_STAT, '1);
    rd(S_STAT, v); check("R9 status write ignored", v, 32'h0000_0088);
    wr(S_ACK, '0);
    rd(S_STAT, v); check("R6 zero ack no effect", v, 32'h0000_0088);
    wr(S_ACK, 32'h0000_0008);
    rd(S_STAT, v); check("R6 partial ack", v, 32'h0000_0080);
    check("R8 irq held while pending", {31'd0, irq_o}, 32'd1);
    // R7: new edge on pin 7 coincides with its acknowledge
    pin_lvl[7] = 1'b1; step();
    pin_lvl[7] = 1'b0;
    wr(S_ACK, 32'h0000_0080);
    rd(S_STAT, v); check("R7 edge wins over ack", v, 32'h0000_0080);
    wr(S_ACK, 32'h0000_0080);
    check("R8 irq drops with last ack", {31'd0, irq_o}, '0);
    rd(S_STAT, v); check("R6 ack clears", v, '0);
    // R5: masked edge is not recorded, nor recalled on enable
    pin_lvl = '1; step();
    wr(S_FALL, '0);
    pin_lvl[3] = 1'b0; step();
    rd(S_STAT, v); check("R5 masked edge dropped", v, '0);
    wr(S_FALL, '1);
    rd(S_STAT, v); check("R5 enable not retroactive", v, '0);
    // R6: mask change does not clear a pending bit
    pin_lvl[0] = 1'b0; step();
    wr(S_FALL, '0);
    rd(S_STAT, v); check("R6 pending survives mask clear", v, 32'h0000_0001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule